// File: doc/BRIEF.md
# Filtered Interrupt Front End for GPIO Lines

This block sits between a set of GPIO-derived interrupt sources and a downstream interrupt controller. Each line first passes through a two-flop synchronizer. It can then be routed through a glitch filter, whose hold time comes from a single cycle count shared by every line. Finally, an output stage either passes the level on as an active-high request or turns it into edge events.

In level mode, an enabled line's level goes straight to the downstream controller. In both-edge mode, every change of the filtered value, rising or falling, becomes a one-clock low pulse. The downstream controller therefore only has to be set up for falling edges. Both-edge detection depends on the filter, so a line in that mode with its filter bit clear never pulses.

Four 32-bit registers hold the configuration. They sit in a 16-byte window and are selected by byte address bits [3:2]. Software writes and reads them through a simple single-cycle register port.

Top module: `gpirq_front`

## Requirements
- R1: After reset, all four registers read 0 and every `irq_out` bit is 0.
- R2: The register selected by `reg_addr[3:2]` is written when `reg_wr` is high at a clock edge. The selections are: 0 = line enable, 1 = mode (1 = both-edge), 2 = filter enable, 3 = filter cycle count. `reg_rdata` returns the selected register combinationally. Bits at or above NLINES, and cycle-count bits at or above FLT_W, read as 0.
- R3: A line whose enable bit is 0 drives 0 on its `irq_out` bit, whatever its input and other settings.
- R4: An enabled line in level mode (mode bit 0) with its filter bit 0 drives its `irq_out` bit with the input value. The value appears after two clock edges of synchronization.
- R5: With the filter bit set, a line's filtered value takes a new input level only after the synchronized input has differed from it for N consecutive clocks, where N is the cycle count. A count of 0 behaves as 1. A shorter excursion is discarded. In level mode the output follows the filtered value, so a change at the input shows up after 2+N clock edges.
- R6: An enabled line with both its mode bit and its filter bit at 1 rests high on `irq_out`. For each rising or falling change of its filtered value, it drives low for exactly one clock, in the cycle that follows the filter update.
- R7: An enabled line with its mode bit at 1 and its filter bit at 0 holds its `irq_out` bit high and never pulses.
- R8: The filter cycle count is a single value used by all lines. Rewriting it changes the delay on every filtered line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Byte address within the 16-byte register window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the register selected by reg_addr |
| line_in | input | NLINES | Raw interrupt source levels, asynchronous |
| irq_out | output | NLINES | Per-line request to the downstream controller |

## Verification
The bench builds the block with its defaults, 24 lines and an 8-bit cycle count. With 24 lines, a write of all ones shows that the top eight bits read as zero. With 8 bits, a wider write shows the cycle count truncating. Filter delays of 0, 2 and 4 clocks are short enough to count clock by clock, so the exact cycle of the single-cycle low pulse can be checked for both edge directions. Changing the shared count between tests on different lines shows that one value governs every line.

// File: rtl/gpirq_pkg.sv
package gpirq_pkg;
  localparam int REG_W = 32;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_MODE   = 2'd1,
    SEL_FLTEN  = 2'd2,
    SEL_CYCLES = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpirq_regs.sv
module gpirq_regs
  import gpirq_pkg::*;
#(
  parameter int NLINES = 24,
  parameter int FLT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [3:0]        addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [NLINES-1:0] en,
  output logic [NLINES-1:0] mode,
  output logic [NLINES-1:0] fen,
  output logic [FLT_W-1:0]  cyc
);
  reg_sel_e sel;
  logic [NLINES-1:0] en_d, mode_d, fen_d;
  logic [FLT_W-1:0]  cyc_d;

  assign sel = reg_sel_e'(addr[3:2]);

  always_comb begin
    en_d   = en;
    mode_d = mode;
    fen_d  = fen;
    cyc_d  = cyc;
    if (wr) begin
      case (sel)
        SEL_ENABLE: en_d   = wdata[NLINES-1:0];
        SEL_MODE:   mode_d = wdata[NLINES-1:0];
        SEL_FLTEN:  fen_d  = wdata[NLINES-1:0];
        default:    cyc_d  = wdata[FLT_W-1:0];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en   <= '0;
      mode <= '0;
      fen  <= '0;
      cyc  <= '0;
    end else if (wr) begin
      en   <= en_d;
      mode <= mode_d;
      fen  <= fen_d;
      cyc  <= cyc_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_ENABLE: rdata[NLINES-1:0] = en;
      SEL_MODE:   rdata[NLINES-1:0] = mode;
      SEL_FLTEN:  rdata[NLINES-1:0] = fen;
      default:    rdata[FLT_W-1:0]  = cyc;
    endcase
  end
endmodule

// File: rtl/gpirq_filter.sv
module gpirq_filter #(
  parameter int NLINES = 24,
  parameter int FLT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] raw,
  input  logic [NLINES-1:0] fen,
  input  logic [FLT_W-1:0]  cyc,
  output logic [NLINES-1:0] sync,
  output logic [NLINES-1:0] filt
);
  logic [FLT_W-1:0] limit;

  // a zero count is treated as a one-clock hold
  assign limit = (cyc == '0) ? FLT_W'(1) : cyc;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [1:0]       meta_q;
    logic [FLT_W-1:0] cnt_q, cnt_d, cnt_inc;
    logic             flt_q, flt_d;

    assign cnt_inc = cnt_q + 1'b1;

    always_comb begin
      flt_d = flt_q;
      cnt_d = '0;
      if (!fen[i]) begin
        flt_d = meta_q[1];
      end else if (meta_q[1] != flt_q) begin
        if (cnt_inc >= limit) flt_d = meta_q[1];
        else                  cnt_d = cnt_inc;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= '0;
        cnt_q  <= '0;
        flt_q  <= 1'b0;
      end else begin
        meta_q <= {meta_q[0], raw[i]};
        cnt_q  <= cnt_d;
        flt_q  <= flt_d;
      end
    end

    assign sync[i] = meta_q[1];
    assign filt[i] = flt_q;
  end
endmodule

// File: rtl/gpirq_shape.sv
module gpirq_shape #(
  parameter int NLINES = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] en,
  input  logic [NLINES-1:0] mode,
  input  logic [NLINES-1:0] fen,
  input  logic [NLINES-1:0] sync,
  input  logic [NLINES-1:0] filt,
  output logic [NLINES-1:0] irq
);
  logic [NLINES-1:0] prev_q;
  logic [NLINES-1:0] change, level, edge_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= filt;
  end

  always_comb begin
    change = filt ^ prev_q;
    level  = (fen & filt) | (~fen & sync);
    // both-edge needs the filter; without it the line rests high
    edge_n = ~(fen & change);
    irq    = en & ((mode & edge_n) | (~mode & level));
  end
endmodule

// File: rtl/gpirq_front.sv
module gpirq_front
  import gpirq_pkg::*;
#(
  parameter int NLINES = 24,
  parameter int FLT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NLINES-1:0] line_in,
  output logic [NLINES-1:0] irq_out
);
  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic [NLINES-1:0] en_q, mode_q, fen_q, sync_w, filt_w;
  logic [FLT_W-1:0]  cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  gpirq_regs #(.NLINES(NLINES), .FLT_W(FLT_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata),
    .en(en_q), .mode(mode_q), .fen(fen_q), .cyc(cyc_q)
  );

  gpirq_filter #(.NLINES(NLINES), .FLT_W(FLT_W)) u_filt (
    .clk(clk), .rst_n(rst_i_n), .raw(line_in), .fen(fen_q),
    .cyc(cyc_q), .sync(sync_w), .filt(filt_w)
  );

  gpirq_shape #(.NLINES(NLINES)) u_shape (
    .clk(clk), .rst_n(rst_i_n), .en(en_q), .mode(mode_q), .fen(fen_q),
    .sync(sync_w), .filt(filt_w), .irq(irq_out)
  );
endmodule

// File: rtl/gpirq_front_chk.sv
module gpirq_front_chk #(
  parameter int NLINES = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] en,
  input logic [NLINES-1:0] mode,
  input logic [NLINES-1:0] fen,
  input logic [NLINES-1:0] sync,
  input logic [NLINES-1:0] filt,
  input logic [NLINES-1:0] irq
);
  for (genvar k = 0; k < NLINES; k++) begin : g_chk
    assert_disabled_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !en[k] |-> !irq[k]);

    assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (en[k] && !mode[k] && !fen[k]) |-> (irq[k] == sync[k]));

    assert_filter_takes_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (filt[k] != $past(filt[k])) |-> (filt[k] == $past(sync[k])));

    assert_pulse_on_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (en[k] && mode[k] && fen[k] && !irq[k]) |-> (filt[k] != $past(filt[k])));

    assert_unfiltered_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (en[k] && mode[k] && !fen[k]) |-> irq[k]);
  end
endmodule

bind gpirq_front gpirq_front_chk #(.NLINES(NLINES)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .en(en_q), .mode(mode_q), .fen(fen_q),
  .sync(sync_w), .filt(filt_w), .irq(irq_out)
);

// File: tb/gpirq_front_test.sv
module gpirq_front_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 24;
  localparam int NVEC = 11;
  // {enable, mode, filter enable, input, expected irq} for line 0
  localparam logic [4:0] VEC [NVEC] = '{
    5'b0_0_0_1_0, 5'b0_1_1_1_0, 5'b1_0_0_1_1, 5'b1_0_0_0_0,
    5'b1_0_1_1_1, 5'b1_0_1_0_0, 5'b1_1_1_0_1, 5'b1_1_1_1_1,
    5'b1_1_0_1_1, 5'b1_1_0_0_1, 5'b0_0_1_1_0
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0;
  logic [3:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NL-1:0] line_in = '0;
  logic [NL-1:0] irq_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpirq_front #(.NLINES(NL), .FLT_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .line_in(line_in), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] rv;
    string tag;
    ticks(3);
    rst_n = 1'b1;
    ticks(4);

    // R1: reset state
    for (int r = 0; r < 4; r++) begin
      rd(4'(r * 4), rv);
      chk("R1", rv, 32'h0);
    end
    chk("R1", 32'(irq_out), 32'h0);

    // R2: register map, unused bits read zero
    wr(4'h0, 32'hFFFF_FFFF); rd(4'h0, rv); chk("R2", rv, 32'h00FF_FFFF);
    wr(4'h4, 32'h00A5_A5A5); rd(4'h4, rv); chk("R2", rv, 32'h00A5_A5A5);
    wr(4'h8, 32'h0012_3456); rd(4'h8, rv); chk("R2", rv, 32'h0012_3456);
    wr(4'hC, 32'h0000_1234); rd(4'hC, rv); chk("R2", rv, 32'h0000_0034);
    rd(4'h0, rv); chk("R2", rv, 32'h00FF_FFFF);

    // table walk over line 0 configurations (R3, R4, R6, R7)
    wr(4'hC, 32'd1);
    for (int v = 0; v < NVEC; v++) begin
      wr(4'h0, {31'b0, VEC[v][4]});
      wr(4'h4, {31'b0, VEC[v][3]});
      wr(4'h8, {31'b0, VEC[v][2]});
      line_in[0] = VEC[v][1];
      ticks(6);
      if (!VEC[v][4])                 tag = "R3";
      else if (VEC[v][3] && VEC[v][2]) tag = "R6";
      else if (VEC[v][3])             tag = "R7";
      else                            tag = "R4";
      chk(tag, {31'b0, irq_out[0]}, {31'b0, VEC[v][0]});
    end
    line_in = '0;
    ticks(4);

    // R4: two-edge synchronizer latency, unfiltered level mode, line 1
    wr(4'h4, 32'h0); wr(4'h8, 32'h0); wr(4'h0, 32'h2);
    line_in[1] = 1'b1;
    ticks(1); chk("R4", {31'b0, irq_out[1]}, 32'd0);
    ticks(1); chk("R4", {31'b0, irq_out[1]}, 32'd1);

    // R5: glitch shorter than count discarded, then delay 2+N, line 2
    wr(4'hC, 32'd4); wr(4'h8, 32'h4); wr(4'h0, 32'h4);
    ticks(6);
    line_in[2] = 1'b1; ticks(3); line_in[2] = 1'b0;
    for (int c = 0; c < 8; c++) begin
      ticks(1);
      chk("R5", {31'b0, irq_out[2]}, 32'd0);
    end
    line_in[2] = 1'b1;
    ticks(5); chk("R5", {31'b0, irq_out[2]}, 32'd0);
    ticks(1); chk("R5", {31'b0, irq_out[2]}, 32'd1);

    // R5: zero count behaves as one
    wr(4'hC, 32'd0);
    line_in[2] = 1'b0;
    ticks(2); chk("R5", {31'b0, irq_out[2]}, 32'd1);
    ticks(1); chk("R5", {31'b0, irq_out[2]}, 32'd0);

    // R6: both-edge pulses, one clock low at 2+N, line 3, N=4
    wr(4'hC, 32'd4); wr(4'h4, 32'h8); wr(4'h8, 32'h8); wr(4'h0, 32'h8);
    ticks(6);
    line_in[3] = 1'b1;
    for (int c = 1; c <= 8; c++) begin
      ticks(1);
      chk("R6", {31'b0, irq_out[3]}, {31'b0, c != 6});
    end
    line_in[3] = 1'b0;
    for (int c = 1; c <= 8; c++) begin
      ticks(1);
      chk("R6", {31'b0, irq_out[3]}, {31'b0, c != 6});
    end

    // R8: shared count rewritten to 2 moves the pulse on line 7
    wr(4'hC, 32'd2); wr(4'h4, 32'h80); wr(4'h8, 32'h80); wr(4'h0, 32'h80);
    ticks(4);
    line_in[7] = 1'b1;
    for (int c = 1; c <= 6; c++) begin
      ticks(1);
      chk("R8", {31'b0, irq_out[7]}, {31'b0, c != 4});
    end

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule